// File: doc/BRIEF.md
# Page Program Buffer with Self-Timed Cycle

This block collects the data bytes of a serial memory write command and then carries out the programming on its own schedule. The serial front end tells it three things: where the command starts, each byte as it completes, and the moment chip select goes high, including whether that moment fell on a byte boundary. A permit from the protection logic decides whether the collected page may be committed at all.

The bytes go into a page buffer that holds one array page. A per-byte mask records which offsets were written. When a commit is accepted, the block raises busy for a fixed number of system clocks given by a parameter. No erase step comes first. During the early part of that interval it replays the marked bytes to the array write port, lowest offset first. When the interval ends it issues a one-cycle done event, which the status logic uses to clear write enable. Only bytes of the addressed page are touched: the in-page offset wraps, and the page number is fixed when the command starts.

Top module: `page_prog_buffer`

## Requirements
- R1: After reset, `busy`, `done` and `arr_we` are all low.
- R2: Each byte strobed after `wr_start` is stored at the current in-page offset. The offset starts at the low log2(PAGE_BYTES) bits of `wr_addr` and advances by one per byte, wrapping from the last offset to 0. The page bits (the bits of `wr_addr` above the offset) are captured at `wr_start`.
- R3: If more than PAGE_BYTES bytes arrive, the offset wraps, and a later byte replaces the earlier one at the same offset. Only the last value written to each offset is committed.
- R4: A `cs_rise` with `cs_aligned` low abandons the command. No busy period and no array writes follow, and the buffered bytes are forgotten by the next command.
- R5: A `cs_rise` with `wr_permit` low abandons the command in the same way.
- R6: An accepted commit is a `cs_rise` with both `cs_aligned` and `wr_permit` high and at least one byte buffered. `busy` rises in the next cycle and stays high for exactly PROG_CYCLES cycles.
- R7: `done` is high for exactly one cycle, the first cycle after `busy` falls, once per programming cycle.
- R8: While busy, each written offset is presented once on the array port with `arr_we` high. Writes go in ascending offset order, with address {page, offset} and the last data stored there. Unwritten offsets produce no write, and `arr_we` is never high outside busy.
- R9: While busy, `wr_start`, byte strobes and `cs_rise` have no effect on the writes being committed or on the length of the busy period.
- R10: A `cs_rise` that arrives with no byte buffered starts no programming cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | One-cycle pulse: a write command with its address has been received |
| wr_addr | input | ADDR_W | Start byte address, sampled with `wr_start` |
| rx_byte_vld | input | 1 | One-cycle strobe: a complete data byte has been received |
| rx_byte | input | 8 | Received data byte |
| cs_rise | input | 1 | One-cycle pulse: chip select has gone inactive |
| cs_aligned | input | 1 | The chip-select rise came directly after a whole byte |
| wr_permit | input | 1 | Write enabled and the target page unprotected |
| busy | output | 1 | Programming cycle in progress |
| done | output | 1 | One-cycle pulse at the end of programming |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | 8 | Array byte data |

## Verification
A stale valid mask shows up as extra array writes in the next programming cycle, so a write that follows an abandoned command exposes it within that cycle. A wrong offset pointer or page latch shows up as wrong addresses or wrong data on the first commit after the fault. A timer fault changes the busy length or moves `done`, which shows at the end of the very first cycle. Faults in the replay scan show up as a broken ascending order or a write outside busy in the cycle they happen.

// File: rtl/page_prog_buffer.sv
module page_prog_buffer #(
  parameter int ADDR_W      = 17,
  parameter int PAGE_BYTES  = 128,
  parameter int PROG_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              rx_byte_vld,
  input  logic [7:0]        rx_byte,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              wr_permit,
  output logic              busy,
  output logic              done,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int TMR_W = $clog2(PROG_CYCLES + 1);
  localparam logic [TMR_W-1:0] PAGE_T = TMR_W'(PAGE_BYTES);
  localparam logic [TMR_W-1:0] LAST_T = TMR_W'(PROG_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_PROG} st_t;

  st_t                    state;
  logic [7:0]             pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]  pmask;
  logic [ADDR_W-OFF_W-1:0] page_q;
  logic [OFF_W-1:0]       ptr;
  logic [TMR_W-1:0]       tmr;

  wire              take_byte = (state == S_FILL) && rx_byte_vld && !cs_rise;
  wire              commit    = cs_rise && cs_aligned && wr_permit && (|pmask);
  wire              scan      = (state == S_PROG) && (tmr < PAGE_T);
  wire [OFF_W-1:0]  scan_off  = tmr[OFF_W-1:0];

  assign busy      = (state == S_PROG);
  assign arr_we    = scan && pmask[scan_off];
  assign arr_addr  = {page_q, scan_off};
  assign arr_wdata = pbuf[scan_off];

  always_ff @(posedge clk) begin
    if (take_byte) pbuf[ptr] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pmask  <= '0;
      page_q <= '0;
      ptr    <= '0;
      tmr    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (wr_start) begin
            page_q <= wr_addr[ADDR_W-1:OFF_W];
            ptr    <= wr_addr[OFF_W-1:0];
            pmask  <= '0;
            state  <= S_FILL;
          end
        end
        S_FILL: begin
          if (cs_rise) begin
            tmr <= '0;
            if (commit) state <= S_PROG;
            else begin
              state <= S_IDLE;
              pmask <= '0;
            end
          end else if (rx_byte_vld) begin
            pmask[ptr] <= 1'b1;
            ptr        <= ptr + 1'b1;
          end
        end
        S_PROG: begin
          if (tmr == LAST_T) begin
            state <= S_IDLE;
            pmask <= '0;
            done  <= 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_prog_buffer_chk.sv
module page_prog_buffer_chk #(
  parameter int ADDR_W      = 17,
  parameter int OFF_W       = 7,
  parameter int PROG_CYCLES = 500000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise,
  input logic              busy,
  input logic              done,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr
);
  logic [OFF_W-1:0] last_off;
  logic             seen;
  logic [31:0]      bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_off <= '0;
      seen     <= 1'b0;
      bcnt     <= '0;
    end else begin
      bcnt <= busy ? bcnt + 32'd1 : 32'd0;
      if (!busy) seen <= 1'b0;
      else if (arr_we) begin
        seen     <= 1'b1;
        last_off <= arr_addr[OFF_W-1:0];
      end
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !done && !arr_we);
  a_r6_busy_after_cs: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(cs_rise));
  a_r6_busy_bound: assert property (@(posedge clk) disable iff (!rst_n) busy |-> bcnt < PROG_CYCLES);
  a_r7_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r8_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n) arr_we |-> busy);
  a_r8_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && seen) |-> arr_addr[OFF_W-1:0] > last_off);
  a_r9_page_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> arr_addr[ADDR_W-1:OFF_W] == $past(arr_addr[ADDR_W-1:OFF_W]));
endmodule

bind page_prog_buffer page_prog_buffer_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .busy(busy), .done(done),
  .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/page_prog_buffer_bench.sv
module page_prog_buffer_bench;
  localparam int ADDR_W = 17;
  localparam int PAGE   = 128;
  localparam int PROG   = 300;
  localparam int OFF_W  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_start = 1'b0, rx_byte_vld = 1'b0, cs_rise = 1'b0;
  logic cs_aligned = 1'b0, wr_permit = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] rx_byte = '0;
  logic busy, done, arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [7:0] arr_wdata;

  always #2 clk = ~clk;

  page_prog_buffer #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .PROG_CYCLES(PROG)) u_page_prog_buffer (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
    .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte), .cs_rise(cs_rise),
    .cs_aligned(cs_aligned), .wr_permit(wr_permit), .busy(busy), .done(done),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata));

  int n_run = 0, n_fail = 0, cyc = 0;

  logic [ADDR_W-1:0] log_addr [256];
  logic [7:0]        log_data [256];
  int log_n, busy_cyc, done_n, done_fall, we_idle;
  logic prev_busy = 1'b0;

  logic [7:0] exp_data [PAGE];
  logic [PAGE-1:0] exp_mask;
  logic [ADDR_W-OFF_W-1:0] exp_page;
  logic [OFF_W-1:0] exp_off;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (busy) busy_cyc = busy_cyc + 1;
      if (arr_we && !busy) we_idle = we_idle + 1;
      if (arr_we && log_n < 256) begin
        log_addr[log_n] = arr_addr;
        log_data[log_n] = arr_wdata;
        log_n = log_n + 1;
      end
      if (done) done_n = done_n + 1;
      if (prev_busy && !busy && done) done_fall = done_fall + 1;
      prev_busy = busy;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clear_mon();
    log_n = 0; busy_cyc = 0; done_n = 0; done_fall = 0; we_idle = 0;
  endtask

  task automatic cmd(input logic [ADDR_W-1:0] a);
    wr_start = 1'b1; wr_addr = a;
    @(negedge clk); wr_start = 1'b0;
    exp_page = a[ADDR_W-1:OFF_W]; exp_off = a[OFF_W-1:0]; exp_mask = '0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit model);
    rx_byte_vld = 1'b1; rx_byte = d;
    @(negedge clk); rx_byte_vld = 1'b0;
    if (model) begin
      exp_data[exp_off] = d; exp_mask[exp_off] = 1'b1; exp_off = exp_off + 1'b1;
    end
  endtask

  task automatic finish(input bit al, input bit pm);
    cs_rise = 1'b1; cs_aligned = al; wr_permit = pm;
    @(negedge clk); cs_rise = 1'b0; cs_aligned = 1'b0; wr_permit = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_commit(input string req);
    int k = 0;
    int bad = 0;
    for (int o = 0; o < PAGE; o++) begin
      if (exp_mask[o]) begin
        if (k >= log_n || log_addr[k] != {exp_page, OFF_W'(o)} || log_data[k] != exp_data[o]) bad++;
        k++;
      end
    end
    chk(log_n == k, {req, " write count"}, log_n, k);
    chk(bad == 0, {req, " write address/data/order"}, bad, 0);
    chk(busy_cyc == PROG, "R6 busy length", busy_cyc, PROG);
    chk(done_n == 1 && done_fall == 1, "R7 done pulse after busy", done_n * 10 + done_fall, 11);
    chk(we_idle == 0, "R8 no write outside busy", we_idle, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !arr_we, "R1 reset outputs", {busy, done, arr_we}, 0);
  endtask

  task automatic t_single();
    clear_mon();
    cmd(17'h12345); send_byte(8'hA5, 1); finish(1, 1);
    wait_cycles(PROG + 10);
    check_commit("R2 R8 single byte");
  endtask

  task automatic t_in_page_wrap();
    clear_mon();
    cmd(17'h0A57E);
    for (int i = 0; i < 4; i++) send_byte(8'h30 + 8'(i), 1);
    finish(1, 1);
    wait_cycles(PROG + 10);
    check_commit("R2 offset wrap in page");
  endtask

  task automatic t_overflow();
    clear_mon();
    cmd(17'h1FF80);
    for (int i = 0; i < 130; i++) send_byte(8'(i * 3 + 1), 1);
    finish(1, 1);
    wait_cycles(PROG + 10);
    check_commit("R3 overflow overwrite");
    chk(log_n > 0 && log_data[0] == 8'(128 * 3 + 1), "R3 offset 0 holds last byte",
        log_n > 0 ? int'(log_data[0]) : -1, 8'(128 * 3 + 1));
  endtask

  task automatic t_abort(input bit al, input bit pm, input string req);
    clear_mon();
    cmd(17'h04400);
    for (int i = 0; i < 6; i++) send_byte(8'hC0 + 8'(i), 0);
    finish(al, pm);
    wait_cycles(40);
    chk(busy_cyc == 0, {req, " no busy"}, busy_cyc, 0);
    chk(log_n == 0 && done_n == 0, {req, " no write/done"}, log_n + done_n, 0);
    clear_mon();
    cmd(17'h04410); send_byte(8'h5A, 1); send_byte(8'h6B, 1); finish(1, 1);
    wait_cycles(PROG + 10);
    check_commit({req, " stale bytes forgotten"});
  endtask

  task automatic t_empty();
    clear_mon();
    cmd(17'h00200); finish(1, 1);
    wait_cycles(40);
    chk(busy_cyc == 0 && done_n == 0, "R10 empty command no cycle", busy_cyc + done_n, 0);
  endtask

  task automatic t_busy_ignore();
    clear_mon();
    cmd(17'h15500);
    for (int i = 0; i < 3; i++) send_byte(8'h71 + 8'(i), 1);
    finish(1, 1);
    wait_cycles(20);
    wr_start = 1'b1; wr_addr = 17'h00000; @(negedge clk); wr_start = 1'b0;
    for (int i = 0; i < 5; i++) send_byte(8'hEE, 0);
    cs_rise = 1'b1; cs_aligned = 1'b1; wr_permit = 1'b1; @(negedge clk);
    cs_rise = 1'b0; cs_aligned = 1'b0; wr_permit = 1'b0;
    wait_cycles(PROG + 10);
    check_commit("R9 inputs ignored while busy");
    chk(!busy, "R9 idle after cycle", busy, 0);
  endtask

  initial begin
    while (cyc < 150000) @(negedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_cycles(3);
    t_reset();
    rst_n = 1'b1;
    wait_cycles(2);
    t_reset();
    t_single();
    t_in_page_wrap();
    t_overflow();
    t_abort(0, 1, "R4 misaligned");
    t_abort(1, 0, "R5 not permitted");
    t_empty();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule